// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block sits between a set of shared external interrupt sources and the per-core interrupt inputs of a multicore cluster. Every shared source has its own small configuration: a destination core mask, a distribution mode, a trigger type and a mask bit. Each source drives its own line on every core. A source that is unmasked, while the block is globally enabled, reaches either all cores in its destination mask or, in round-robin mode, one of them at a time. The choice rotates from one assertion to the next.

Software programs the block through a single-cycle command port. A command carries an operation code, a source index and a data word. The commands set the destination mask, set the mode, mask or unmask a source, switch distribution on or off globally, and acknowledge a latched edge. A read-only build value reports how many shared sources the block was built with. On each core, shared source i appears on core interrupt line `BASE_LINE + i`. That line number follows the core-private lines 16 to 23.

Top module: `shirq_distrib`

## Requirements
- R1: After reset every shared source is masked and global distribution is off, so `core_irq_o` is all zero whatever `irq_i` does.
- R2: A command with op 1 writes `cmd_data_i[NUM_CORE-1:0]` as the destination mask of source `cmd_idx_i`, with one bit per core. It takes effect from the cycle after the command. After reset every destination mask is all ones.
- R3: A command with op 2 writes the mode of the indexed source. Bits [1:0] pick the distribution: value 1 is round-robin and values 0, 2 and 3 all deliver to the whole destination mask. Bit 4 picks the trigger: 1 is level, 0 is edge. After reset a source is in level trigger and delivers to the whole mask.
- R4: A command with op 3 masks the indexed source when `cmd_data_i[0]` is 1 and unmasks it when that bit is 0. A masked source drives no core line.
- R5: A command with op 4 turns global distribution on when `cmd_data_i[0]` is 1 and off when it is 0. While distribution is off, every output is zero.
- R6: Source i drives core c on bit `c*NUM_IRQ + i` of `core_irq_o`. That bit is the core's interrupt line `BASE_LINE + i`.
- R7: In level trigger, an enabled and unmasked source asserts its selected core lines in the same cycle as `irq_i[i]` is high, and drops them in the same cycle as the input falls.
- R8: In round-robin mode each new assertion goes to exactly one core. That core is the next set bit of the destination mask after the previously chosen core, wrapping from the top core to core 0. The first choice after reset is the lowest set bit. The line stays on that core while the assertion lasts.
- R9: In edge trigger, a rising edge of `irq_i[i]` sampled at a clock edge sets a pending flag. The flag drives the output from the next cycle on, even after the input falls, and stays set until a command with op 5 for that index clears it one cycle later. If a new edge and the clear arrive in the same cycle, the flag stays set.
- R10: A command whose index is `NUM_IRQ` or above changes nothing.
- R11: `build_o` always equals `NUM_IRQ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Shared interrupt inputs, synchronous to clk |
| cmd_vld_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Operation: 1 destination, 2 mode, 3 mask, 4 global enable, 5 acknowledge |
| cmd_idx_i | input | IDX_W | Shared source index |
| cmd_data_i | input | DATA_W | Command data word |
| core_irq_o | output | NUM_CORE*NUM_IRQ | Per-core interrupt lines, core-major |
| build_o | output | 16 | Number of shared sources |

## Verification
The assertions assume that `irq_i` is already synchronous to `clk`, and that a command is a single-cycle strobe whose data is stable at the sampling edge. They also assume that no command changes a source's configuration while that source's pending edge is being held. The bench drives every input on the falling edge and holds each command for exactly one cycle. In each edge scenario it sends only the acknowledge while a pending flag is held. It pulses the round-robin source with at least one idle cycle between assertions, so that each pulse counts as a new assertion.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_DEST   = 3'd1,
      OP_MODE   = 3'd2,
      OP_MASK   = 3'd3,
      OP_ENABLE = 3'd4,
      OP_ACK    = 3'd5
   } shirq_op_e;

   localparam logic [1:0] DIST_ROTATE = 2'd1;
   localparam int         TRIG_BIT    = 4;
   localparam int         FIRST_SHARED_LINE = 24;

endpackage

// File: rtl/shirq_cmd_dec.sv
module shirq_cmd_dec
   import shirq_pkg::*;
#(
   parameter int NUM_IRQ = 8,
   parameter int IDX_W   = 4
) (
   input  logic               cmd_vld_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [IDX_W-1:0]   cmd_idx_i,
   output logic [NUM_IRQ-1:0] wr_dest_o,
   output logic [NUM_IRQ-1:0] wr_mode_o,
   output logic [NUM_IRQ-1:0] wr_mask_o,
   output logic [NUM_IRQ-1:0] ack_o,
   output logic               wr_en_o
);

   shirq_op_e op;
   assign op = shirq_op_e'(cmd_op_i);

   assign wr_en_o = cmd_vld_i && (op == OP_ENABLE);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_sel
      logic hit;
      assign hit          = cmd_vld_i && (cmd_idx_i == IDX_W'(i));
      assign wr_dest_o[i] = hit && (op == OP_DEST);
      assign wr_mode_o[i] = hit && (op == OP_MODE);
      assign wr_mask_o[i] = hit && (op == OP_MASK);
      assign ack_o[i]     = hit && (op == OP_ACK);
   end

endmodule

// File: rtl/shirq_rr_pick.sv
module shirq_rr_pick #(
   parameter int NUM_CORE = 4,
   localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
   input  logic [NUM_CORE-1:0] dest_i,
   input  logic [CW-1:0]       last_i,
   output logic [CW-1:0]       pick_o
);

   always_comb begin
      logic found;
      found  = 1'b0;
      pick_o = last_i;
      for (int k = 1; k <= NUM_CORE; k++) begin
         if (!found && dest_i[(int'(last_i) + k) % NUM_CORE]) begin
            found  = 1'b1;
            pick_o = CW'((int'(last_i) + k) % NUM_CORE);
         end
      end
   end

endmodule

// File: rtl/shirq_chan.sv
module shirq_chan
   import shirq_pkg::*;
#(
   parameter int NUM_CORE = 4,
   localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                irq_i,
   input  logic                glb_en_i,
   input  logic                wr_dest_i,
   input  logic                wr_mode_i,
   input  logic                wr_mask_i,
   input  logic                ack_i,
   input  logic [NUM_CORE-1:0] dest_data_i,
   input  logic [1:0]          mode_data_i,
   input  logic                trig_data_i,
   input  logic                mask_data_i,
   output logic [NUM_CORE-1:0] lines_o
);

   logic [NUM_CORE-1:0] dest_q;
   logic [1:0]          mode_q;
   logic                level_q;
   logic                mask_q;
   logic                pend_q;
   logic                prev_q;
   logic                act_d_q;
   logic [CW-1:0]       last_q;

   logic                act;
   logic                rotate;
   logic                rise;
   logic [CW-1:0]       pick;
   logic [CW-1:0]       cur;
   logic [NUM_CORE-1:0] cur_oh;

   shirq_rr_pick #(.NUM_CORE(NUM_CORE)) u_pick (
      .dest_i (dest_q),
      .last_i (last_q),
      .pick_o (pick)
   );

   assign rotate = (mode_q == DIST_ROTATE);
   assign act    = glb_en_i && !mask_q && (level_q ? irq_i : pend_q);
   assign rise   = act && !act_d_q;
   assign cur    = rise ? pick : last_q;

   always_comb begin
      cur_oh      = '0;
      cur_oh[cur] = 1'b1;
   end

   always_comb begin
      if (!act)
         lines_o = '0;
      else if (rotate)
         lines_o = cur_oh & dest_q;
      else
         lines_o = dest_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_q  <= '1;
         mode_q  <= 2'd0;
         level_q <= 1'b1;
         mask_q  <= 1'b1;
         pend_q  <= 1'b0;
         prev_q  <= 1'b0;
         act_d_q <= 1'b0;
         last_q  <= CW'(NUM_CORE - 1);
      end else begin
         if (wr_dest_i) dest_q <= dest_data_i;
         if (wr_mode_i) begin
            mode_q  <= mode_data_i;
            level_q <= trig_data_i;
         end
         if (wr_mask_i) mask_q <= mask_data_i;
         prev_q <= irq_i;
         if (irq_i && !prev_q)
            pend_q <= 1'b1;
         else if (ack_i)
            pend_q <= 1'b0;
         act_d_q <= act;
         if (rise && rotate) last_q <= pick;
      end
   end

endmodule

// File: rtl/shirq_distrib.sv
module shirq_distrib
   import shirq_pkg::*;
#(
   parameter int NUM_IRQ   = 8,
   parameter int NUM_CORE  = 4,
   parameter int IDX_W     = 4,
   parameter int DATA_W    = 32,
   parameter int BASE_LINE = FIRST_SHARED_LINE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_IRQ-1:0]           irq_i,
   input  logic                         cmd_vld_i,
   input  logic [2:0]                   cmd_op_i,
   input  logic [IDX_W-1:0]             cmd_idx_i,
   input  logic [DATA_W-1:0]            cmd_data_i,
   output logic [NUM_CORE*NUM_IRQ-1:0]  core_irq_o,
   output logic [15:0]                  build_o
);

   if (NUM_CORE < 2) begin : g_bad_core
      $error("NUM_CORE must be at least 2");
   end
   if ((1 << IDX_W) < NUM_IRQ) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_IRQ");
   end
   if (DATA_W < TRIG_BIT + 1 || DATA_W < NUM_CORE) begin : g_bad_data
      $error("DATA_W too narrow");
   end
   if (BASE_LINE < FIRST_SHARED_LINE) begin : g_bad_base
      $error("BASE_LINE overlaps core-private lines");
   end

   logic [NUM_IRQ-1:0]  wr_dest;
   logic [NUM_IRQ-1:0]  wr_mode;
   logic [NUM_IRQ-1:0]  wr_mask;
   logic [NUM_IRQ-1:0]  ack;
   logic                wr_en;
   logic                glb_en_q;
   logic                unused_data;

   assign unused_data = ^cmd_data_i;
   assign build_o     = 16'(NUM_IRQ);

   shirq_cmd_dec #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_dec (
      .cmd_vld_i (cmd_vld_i),
      .cmd_op_i  (cmd_op_i),
      .cmd_idx_i (cmd_idx_i),
      .wr_dest_o (wr_dest),
      .wr_mode_o (wr_mode),
      .wr_mask_o (wr_mask),
      .ack_o     (ack),
      .wr_en_o   (wr_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     glb_en_q <= 1'b0;
      else if (wr_en) glb_en_q <= cmd_data_i[0];
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chan
      logic [NUM_CORE-1:0] lines;

      shirq_chan #(.NUM_CORE(NUM_CORE)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .irq_i       (irq_i[i]),
         .glb_en_i    (glb_en_q),
         .wr_dest_i   (wr_dest[i]),
         .wr_mode_i   (wr_mode[i]),
         .wr_mask_i   (wr_mask[i]),
         .ack_i       (ack[i]),
         .dest_data_i (cmd_data_i[NUM_CORE-1:0]),
         .mode_data_i (cmd_data_i[1:0]),
         .trig_data_i (cmd_data_i[TRIG_BIT]),
         .mask_data_i (cmd_data_i[0]),
         .lines_o     (lines)
      );

      for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
         assign core_irq_o[c*NUM_IRQ + i] = lines[c];
      end
   end

endmodule

// File: rtl/shirq_chk.sv
module shirq_chk
   import shirq_pkg::*;
#(
   parameter int NUM_IRQ   = 8,
   parameter int NUM_CORE  = 4,
   parameter int IDX_W     = 4,
   parameter int DATA_W    = 32,
   parameter int BASE_LINE = FIRST_SHARED_LINE
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_IRQ-1:0]          irq_i,
   input  logic                        cmd_vld_i,
   input  logic [2:0]                  cmd_op_i,
   input  logic [IDX_W-1:0]            cmd_idx_i,
   input  logic [DATA_W-1:0]           cmd_data_i,
   input  logic [NUM_CORE*NUM_IRQ-1:0] core_irq_o
);

   logic                unused_chk;
   logic                en_s;
   logic [NUM_IRQ-1:0]  mask_s;
   logic [NUM_IRQ-1:0]  rot_s;
   logic [NUM_IRQ-1:0]  lvl_s;
   logic [NUM_CORE-1:0] col [NUM_IRQ];

   assign unused_chk = ^cmd_data_i ^ (BASE_LINE > 0);

   always_comb begin
      for (int i = 0; i < NUM_IRQ; i++)
         for (int c = 0; c < NUM_CORE; c++)
            col[i][c] = core_irq_o[c*NUM_IRQ + i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_s   <= 1'b0;
         mask_s <= '1;
         rot_s  <= '0;
         lvl_s  <= '1;
      end else if (cmd_vld_i) begin
         if (cmd_op_i == OP_ENABLE) en_s <= cmd_data_i[0];
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (int'(cmd_idx_i) == i) begin
               if (cmd_op_i == OP_MASK) mask_s[i] <= cmd_data_i[0];
               if (cmd_op_i == OP_MODE) begin
                  rot_s[i] <= (cmd_data_i[1:0] == DIST_ROTATE);
                  lvl_s[i] <= cmd_data_i[TRIG_BIT];
               end
            end
         end
      end
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> core_irq_o == '0); // R5

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         mask_s[i] |-> col[i] == '0); // R4
      AST_ROTATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         rot_s[i] |-> $onehot0(col[i])); // R8
      AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_s[i] && !irq_i[i]) |-> col[i] == '0); // R7
      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_s[i] && col[i] != '0 && !cmd_vld_i) |=> col[i] == $past(col[i])); // R9
   end

endmodule

bind shirq_distrib shirq_chk #(
   .NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .IDX_W(IDX_W),
   .DATA_W(DATA_W), .BASE_LINE(BASE_LINE)
) u_chk (.*);

// File: tb/shirq_distrib_bench.sv
module shirq_distrib_bench;

   localparam int NI = 8;
   localparam int NC = 4;
   localparam int IW = 4;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NI-1:0]     irq_i = '0;
   logic              cmd_vld_i = 1'b0;
   logic [2:0]        cmd_op_i = '0;
   logic [IW-1:0]     cmd_idx_i = '0;
   logic [DW-1:0]     cmd_data_i = '0;
   logic [NC*NI-1:0]  core_irq_o;
   logic [15:0]       build_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   shirq_distrib u_shirq_distrib (.*);

   function automatic logic [NC*NI-1:0] col(int i, logic [NC-1:0] cores);
      logic [NC*NI-1:0] v = '0;
      for (int c = 0; c < NC; c++) v[c*NI + i] = cores[c];
      return v;
   endfunction

   task automatic chk(logic [NC*NI-1:0] act, logic [NC*NI-1:0] exp, string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(logic [2:0] op, int idx, logic [DW-1:0] data);
      @(negedge clk);
      cmd_vld_i  = 1'b1;
      cmd_op_i   = op;
      cmd_idx_i  = IW'(idx);
      cmd_data_i = data;
      @(negedge clk);
      cmd_vld_i  = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(core_irq_o, '0, "R1 idle");
      chk({16'd0, build_o}, 32'(NI), "R11 build");
      irq_i = '1; #1;
      chk(core_irq_o, '0, "R1 inputs high after reset");
      irq_i = '0;
   endtask

   task automatic t_level_route();
      cmd(3'd4, 0, 32'h1);
      cmd(3'd1, 2, 32'h5);
      cmd(3'd2, 2, 32'h10);
      cmd(3'd3, 2, 32'h0);
      @(negedge clk); irq_i[2] = 1'b1; #1;
      chk(core_irq_o, col(2, 4'b0101), "R2 R6 R7 level routed");
      @(negedge clk); #1;
      chk(core_irq_o, col(2, 4'b0101), "R7 level held");
      irq_i[2] = 1'b0; #1;
      chk(core_irq_o, '0, "R7 level dropped");
   endtask

   task automatic t_mask();
      irq_i[2] = 1'b1;
      cmd(3'd3, 2, 32'h1);
      chk(core_irq_o, '0, "R4 masked");
      cmd(3'd3, 2, 32'h0);
      chk(core_irq_o, col(2, 4'b0101), "R4 unmasked");
   endtask

   task automatic t_enable();
      cmd(3'd4, 0, 32'h0);
      chk(core_irq_o, '0, "R5 disabled");
      cmd(3'd4, 0, 32'h1);
      chk(core_irq_o, col(2, 4'b0101), "R5 re-enabled");
      irq_i[2] = 1'b0;
   endtask

   task automatic t_rotate();
      int seq [4] = '{0, 1, 3, 0};
      cmd(3'd1, 5, 32'hB);
      cmd(3'd2, 5, 32'h11);
      cmd(3'd3, 5, 32'h0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); irq_i[5] = 1'b1; #1;
         chk(core_irq_o, col(5, 4'(1 << seq[k])), "R8 rotate pick");
         @(negedge clk); #1;
         chk(core_irq_o, col(5, 4'(1 << seq[k])), "R8 rotate hold");
         irq_i[5] = 1'b0; #1;
         chk(core_irq_o, '0, "R8 rotate drop");
         @(negedge clk);
      end
      cmd(3'd2, 5, 32'h12);
      irq_i[5] = 1'b1; #1;
      chk(core_irq_o, col(5, 4'hB), "R3 mode 2 delivers to mask");
      irq_i[5] = 1'b0; #1;
   endtask

   task automatic t_edge();
      cmd(3'd1, 6, 32'h2);
      cmd(3'd2, 6, 32'h0);
      cmd(3'd3, 6, 32'h0);
      @(negedge clk); irq_i[6] = 1'b1; #1;
      chk(core_irq_o, '0, "R9 edge not yet pending");
      @(negedge clk); irq_i[6] = 1'b0; #1;
      chk(core_irq_o, col(6, 4'b0010), "R9 edge pending");
      repeat (3) @(negedge clk);
      #1;
      chk(core_irq_o, col(6, 4'b0010), "R9 pending held");
      cmd(3'd5, 6, 32'h0);
      chk(core_irq_o, '0, "R9 acknowledged");
   endtask

   task automatic t_range();
      irq_i[1] = 1'b1;
      cmd(3'd3, 9, 32'h0);
      chk(core_irq_o, '0, "R10 out-of-range index ignored");
      cmd(3'd3, 1, 32'h0);
      chk(core_irq_o, col(1, 4'hF), "R2 R3 reset config of source 1");
      irq_i[1] = 1'b0; #1;
   endtask

   initial begin
      t_reset();
      t_level_route();
      t_mask();
      t_enable();
      t_rotate();
      t_edge();
      t_range();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule